// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetch Engine

This block feeds a display pipeline by following a chain of descriptors held in word-addressed memory. Every descriptor is four words: a link to the following descriptor, the start of the data to move, an identifier for the frame, and a command word. The command word carries the transfer length in 32-bit words and a flag that sends the data to the colour-lookup memory rather than to the pixel queue. Pixel data is read in bursts of at most `BURST` words. A burst is started only when the downstream queue reports room for a full burst. Lookup-table loads are never held back by the queue.

The first frame start after reset takes the chain head from `head_addr`. From then on, each frame start resumes at the link of the last descriptor that moved pixels. A descriptor that links to itself therefore fetches the same buffer on every frame. Two descriptors that link to each other give alternating table loads and pixel fetches. After a lookup-table descriptor, the next descriptor is fetched straight away within the same frame. After a pixel descriptor, the engine waits for the next frame start.

Memory reads use a plain handshake. `mem_req` is held with a stable `mem_addr` until `mem_rvalid` returns the word, and one read is outstanding at a time.

Top module: `frame_desc_dma`

## Requirements
- R1: After reset, `mem_req`, `pix_valid` and `pal_we` are low and `frame_id` is zero, and no read is issued until `frame_start` is pulsed.
- R2: A descriptor fetch reads word addresses P, P+1, P+2, P+3 in that order. Word 0 is the link, word 1 the source address, word 2 the frame identifier, word 3 the command. `mem_req` and `mem_addr` hold until `mem_rvalid`.
- R3: A pixel descriptor reads `cmd[LEN_W-1:0]` words from consecutive addresses starting at the source address. Each word appears on `pix_data` with `pix_valid` one cycle after its `mem_rvalid`, in address order.
- R4: When bit 28 of the command is set, the data words go out on `pal_wdata` with `pal_we`, at `pal_addr` 0, 1, 2, and so on. `pix_valid` stays low for them.
- R5: When a lookup-table descriptor completes, the descriptor at its link is read without waiting. When a pixel descriptor completes, no read is issued until the next `frame_start`.
- R6: A later `frame_start` fetches the descriptor named by the link of the last completed descriptor, and `head_addr` is ignored. A self-linked descriptor is fetched again on each frame.
- R7: A pixel burst starts only when `fifo_room >= BURST`, and no burst is longer than `BURST` words. A final partial burst carries the remainder.
- R8: A descriptor whose length field is zero causes no data reads.
- R9: `frame_id` shows word 2 of the most recently read descriptor. It changes only on the cycle after that word returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| head_addr | input | AW | Chain head word address, used on the first frame only |
| fifo_room | input | ROOM_W | Free entries in the downstream pixel queue |
| mem_req | output | 1 | Read request, held until data returns |
| mem_addr | output | AW | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| pix_valid | output | 1 | Pixel word strobe |
| pix_data | output | DW | Pixel word |
| pal_we | output | 1 | Lookup-table write strobe |
| pal_addr | output | PAL_AW | Lookup-table write index |
| pal_wdata | output | DW | Lookup-table write data |
| frame_id | output | DW | Identifier of the last descriptor read |

## Verification
Every output strobe is registered once. A pixel or lookup-table word is due exactly one cycle after the `mem_rvalid` that carried it, and `frame_id` moves on the cycle after the identifier word returns. The bench logs the read address while `mem_rvalid` is high, when the request is still held. It logs the output strobes at the falling edge, so each result is taken in the cycle it becomes due. The bench models the pixel queue as a fixed capacity minus the words received. This makes the room seen at each burst boundary follow exactly from the words already delivered. The expected number of words moved before a stall is then plain arithmetic on that capacity.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  localparam int DESC_WORDS = 4;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DESC  = 2'd1,
    ST_XGATE = 2'd2,
    ST_XFER  = 2'd3
  } fdma_state_e;
endpackage

// File: rtl/fdma_desc_latch.sv
module fdma_desc_latch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [1:0]    cap_idx,
  input  logic [DW-1:0] cap_data,
  output logic [AW-1:0] link_addr,
  output logic [AW-1:0] src_addr,
  output logic [DW-1:0] fid,
  output logic [DW-1:0] cmd
);
  logic [AW-1:0] link_q, src_q;
  logic [DW-1:0] fid_q, cmd_q;
  logic link_en, src_en, fid_en, cmd_en;

  always_comb begin
    link_en = cap_en && (cap_idx == 2'd0);
    src_en  = cap_en && (cap_idx == 2'd1);
    fid_en  = cap_en && (cap_idx == 2'd2);
    cmd_en  = cap_en && (cap_idx == 2'd3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      src_q  <= '0;
      fid_q  <= '0;
      cmd_q  <= '0;
    end else begin
      if (link_en) link_q <= AW'(cap_data);
      if (src_en)  src_q  <= AW'(cap_data);
      if (fid_en)  fid_q  <= cap_data;
      if (cmd_en)  cmd_q  <= cap_data;
    end
  end

  assign link_addr = link_q;
  assign src_addr  = src_q;
  assign fid       = fid_q;
  assign cmd       = cmd_q;
endmodule

// File: rtl/fdma_xfer_ctr.sv
module fdma_xfer_ctr #(
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int BURST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic [LEN_W-1:0] load_len,
  input  logic             burst_go,
  input  logic             beat,
  output logic [AW-1:0]    cur_addr,
  output logic             last_word,
  output logic             burst_end
);
  localparam int BEAT_W = $clog2(BURST + 1);

  logic [AW-1:0]     addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [BEAT_W-1:0] bcnt_q, bcnt_d;
  logic              upd_en;

  always_comb begin
    upd_en = load || burst_go || beat;
    addr_d = addr_q;
    rem_d  = rem_q;
    bcnt_d = bcnt_q;
    if (load) begin
      addr_d = load_addr;
      rem_d  = load_len;
      bcnt_d = '0;
    end else if (burst_go) begin
      bcnt_d = '0;
    end else if (beat) begin
      addr_d = addr_q + AW'(1);
      rem_d  = rem_q - LEN_W'(1);
      bcnt_d = bcnt_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      bcnt_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign cur_addr  = addr_q;
  assign last_word = (rem_q == LEN_W'(1));
  assign burst_end = last_word || (bcnt_q == BEAT_W'(BURST - 1));
endmodule

// File: rtl/fdma_route.sv
module fdma_route #(
  parameter int DW     = 32,
  parameter int PAL_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              to_pal,
  input  logic              idx_clr,
  input  logic [DW-1:0]     data,
  output logic              pix_valid,
  output logic [DW-1:0]     pix_data,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_addr,
  output logic [DW-1:0]     pal_wdata
);
  logic              pv_q, pw_q;
  logic [DW-1:0]     pd_q, wd_q;
  logic [PAL_AW-1:0] idx_q, wa_q;
  logic              pix_hit, pal_hit;

  always_comb begin
    pix_hit = beat && !to_pal;
    pal_hit = beat && to_pal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q  <= 1'b0;
      pw_q  <= 1'b0;
      pd_q  <= '0;
      wd_q  <= '0;
      wa_q  <= '0;
      idx_q <= '0;
    end else begin
      pv_q <= pix_hit;
      pw_q <= pal_hit;
      if (pix_hit) pd_q <= data;
      if (pal_hit) begin
        wd_q  <= data;
        wa_q  <= idx_q;
        idx_q <= idx_q + PAL_AW'(1);
      end else if (idx_clr) begin
        idx_q <= '0;
      end
    end
  end

  assign pix_valid = pv_q;
  assign pix_data  = pd_q;
  assign pal_we    = pw_q;
  assign pal_addr  = wa_q;
  assign pal_wdata = wd_q;
endmodule

// File: rtl/frame_desc_dma.sv
module frame_desc_dma
  import fdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int LEN_W   = 16,
  parameter int BURST   = 16,
  parameter int ROOM_W  = 8,
  parameter int PAL_BIT = 28,
  parameter int PAL_AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [AW-1:0]     head_addr,
  input  logic [ROOM_W-1:0] fifo_room,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              pix_valid,
  output logic [DW-1:0]     pix_data,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_addr,
  output logic [DW-1:0]     pal_wdata,
  output logic [DW-1:0]     frame_id
);
  localparam logic [ROOM_W-1:0] BURST_ROOM = ROOM_W'(BURST);

  fdma_state_e   state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic [1:0]    widx_q, widx_d;
  logic          widx_en;
  logic          run_q, run_en;
  logic          desc_beat, data_beat, desc_last, desc_done, burst_go, end_pal;
  logic [AW-1:0] link_addr, src_addr, cur_addr;
  logic [DW-1:0] cmd_w;
  logic          last_word, burst_end;

  assign desc_beat = mem_rvalid && (state_q == ST_DESC);
  assign data_beat = mem_rvalid && (state_q == ST_XFER);
  assign desc_last = desc_beat && (widx_q == 2'(DESC_WORDS - 1));
  assign end_pal   = (state_q == ST_DESC) ? mem_rdata[PAL_BIT] : cmd_w[PAL_BIT];

  fdma_desc_latch #(.AW(AW), .DW(DW)) u_desc (
    .clk(clk), .rst_n(rst_n), .cap_en(desc_beat), .cap_idx(widx_q),
    .cap_data(mem_rdata), .link_addr(link_addr), .src_addr(src_addr),
    .fid(frame_id), .cmd(cmd_w)
  );

  fdma_xfer_ctr #(.AW(AW), .LEN_W(LEN_W), .BURST(BURST)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(desc_last), .load_addr(src_addr),
    .load_len(mem_rdata[LEN_W-1:0]), .burst_go(burst_go), .beat(data_beat),
    .cur_addr(cur_addr), .last_word(last_word), .burst_end(burst_end)
  );

  fdma_route #(.DW(DW), .PAL_AW(PAL_AW)) u_route (
    .clk(clk), .rst_n(rst_n), .beat(data_beat), .to_pal(cmd_w[PAL_BIT]),
    .idx_clr(desc_last), .data(mem_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .pal_we(pal_we), .pal_addr(pal_addr),
    .pal_wdata(pal_wdata)
  );

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    ptr_en    = 1'b0;
    widx_d    = widx_q;
    widx_en   = 1'b0;
    run_en    = 1'b0;
    burst_go  = 1'b0;
    desc_done = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (frame_start) begin
          state_d = ST_DESC;
          widx_d  = '0;
          widx_en = 1'b1;
          run_en  = 1'b1;
          if (!run_q) begin
            ptr_d  = head_addr;
            ptr_en = 1'b1;
          end
        end
      end
      ST_DESC: begin
        if (desc_beat) begin
          widx_d  = widx_q + 2'd1;
          widx_en = 1'b1;
          if (desc_last) begin
            if (mem_rdata[LEN_W-1:0] == '0) desc_done = 1'b1;
            else                            state_d   = ST_XGATE;
          end
        end
      end
      ST_XGATE: begin
        if (cmd_w[PAL_BIT] || (fifo_room >= BURST_ROOM)) begin
          state_d  = ST_XFER;
          burst_go = 1'b1;
        end
      end
      ST_XFER: begin
        if (data_beat && burst_end) begin
          if (last_word) desc_done = 1'b1;
          else           state_d   = ST_XGATE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (desc_done) begin
      ptr_d   = link_addr;
      ptr_en  = 1'b1;
      widx_d  = '0;
      widx_en = 1'b1;
      state_d = end_pal ? ST_DESC : ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      widx_q  <= '0;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (widx_en) widx_q <= widx_d;
      if (run_en)  run_q  <= 1'b1;
    end
  end

  assign mem_req  = (state_q == ST_DESC) || (state_q == ST_XFER);
  assign mem_addr = (state_q == ST_XFER) ? cur_addr : (ptr_q + AW'(widx_q));
endmodule

// File: rtl/fdma_chk.sv
module fdma_chk
  import fdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BURST = 16
) (
  input logic          clk,
  input logic          rst_n,
  input fdma_state_e   st,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          pix_valid,
  input logic          pal_we,
  input logic [DW-1:0] frame_id
);
  logic [7:0] beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats_q <= '0;
    else if (st != ST_XFER) beats_q <= '0;
    else if (mem_rvalid) beats_q <= beats_q + 8'd1;
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  // R3
  out_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid || pal_we) |-> $past(mem_rvalid));
  // R4
  one_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && pal_we));
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !mem_req);
  // R7
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beats_q <= 8'(BURST));
  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rvalid && st == ST_DESC) |=> $stable(frame_id));
endmodule

bind frame_desc_dma fdma_chk #(.AW(AW), .DW(DW), .BURST(BURST)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(state_q), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .pix_valid(pix_valid),
  .pal_we(pal_we), .frame_id(frame_id)
);

// File: tb/frame_desc_dma_tb.sv
module frame_desc_dma_tb;
  logic        clk, rst_n, frame_start;
  logic [31:0] head_addr;
  logic [7:0]  fifo_room;
  logic        mem_req, mem_rvalid, pix_valid, pal_we;
  logic [31:0] mem_addr, mem_rdata, pix_data, pal_wdata, frame_id;
  logic [7:0]  pal_addr;

  frame_desc_dma u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .head_addr(head_addr),
    .fifo_room(fifo_room), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .pal_we(pal_we), .pal_addr(pal_addr),
    .pal_wdata(pal_wdata), .frame_id(frame_id)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] mem [0:63];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else if (mem_req && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[mem_addr[5:0]];
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  int addr_log [0:255];
  int pix_log  [0:255];
  int pal_idx  [0:255];
  int pal_dat  [0:255];
  int an, pn, qn;
  initial begin an = 0; pn = 0; qn = 0; end
  always @(negedge clk) begin
    if (mem_rvalid && an < 256) begin addr_log[an] = int'(mem_addr); an = an + 1; end
    if (pix_valid && pn < 256) begin pix_log[pn] = int'(pix_data); pn = pn + 1; end
    if (pal_we && qn < 256) begin
      pal_idx[qn] = int'(pal_addr); pal_dat[qn] = int'(pal_wdata); qn = qn + 1;
    end
  end

  int cap, pbase;
  always_comb fifo_room = 8'(cap - (pn - pbase));

  int checks, fails;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dval(input int a);
    return 32'hD000_0000 | a;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic check_desc(input int b, input int p, input string req);
    for (int k = 0; k < 4; k++) chk(addr_log[b+k] == p + k, req, addr_log[b+k], p + k);
  endtask

  task automatic check_data(input int b, input int s, input int n, input string req);
    for (int k = 0; k < n; k++) chk(addr_log[b+k] == s + k, req, addr_log[b+k], s + k);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int a0, p0, q0;
    checks = 0; fails = 0;
    frame_start = 1'b0; head_addr = '0; cap = 64; pbase = 0; rst_n = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = dval(i);
    mem[0] = 4;  mem[1] = 32; mem[2] = 32'hA5; mem[3] = (1 << 28) | 4;
    mem[4] = 0;  mem[5] = 40; mem[6] = 32'h5A; mem[7] = 20;
    mem[8] = 8;  mem[9] = 48; mem[10] = 7;     mem[11] = 3;
    mem[12] = 12; mem[13] = 16; mem[14] = 3;   mem[15] = 0;
    do_reset();

    // R1: reset state, and no read without a frame start
    chk(!mem_req && !pix_valid && !pal_we, "R1", {mem_req, pix_valid, pal_we}, 0);
    chk(frame_id == 0, "R1", frame_id, 0);
    repeat (10) @(negedge clk);
    chk(an == 0, "R1", an, 0);

    // Chain: table descriptor at 0 linking to pixel descriptor at 4
    for (int f = 0; f < 2; f++) begin
      a0 = an; p0 = pn; q0 = qn;
      head_addr = (f == 0) ? 0 : 32'd8; // second frame must ignore head (R6)
      pulse();
      repeat (200) @(negedge clk);
      chk(an - a0 == 32, "R2", an - a0, 32);
      check_desc(a0, 0, f == 0 ? "R2" : "R6");
      check_data(a0 + 4, 32, 4, "R4");
      check_desc(a0 + 8, 4, "R5");
      check_data(a0 + 12, 40, 20, "R3");
      chk(qn - q0 == 4, "R4", qn - q0, 4);
      for (int k = 0; k < 4; k++) begin
        chk(pal_idx[q0+k] == k, "R4", pal_idx[q0+k], k);
        chk(pal_dat[q0+k] == dval(32 + k), "R4", pal_dat[q0+k], dval(32 + k));
      end
      chk(pn - p0 == 20, "R4", pn - p0, 20);
      for (int k = 0; k < 20; k++)
        chk(pix_log[p0+k] == dval(40 + k), "R3", pix_log[p0+k], dval(40 + k));
      chk(frame_id == 32'h5A, "R9", frame_id, 32'h5A);
      a0 = an;
      repeat (50) @(negedge clk);
      chk(an == a0, "R5", an - a0, 0);
    end

    // Self-linked descriptor at 8, three data words
    do_reset();
    head_addr = 8;
    for (int f = 0; f < 2; f++) begin
      a0 = an; p0 = pn;
      pulse();
      repeat (60) @(negedge clk);
      chk(an - a0 == 7, "R6", an - a0, 7);
      check_desc(a0, 8, "R6");
      check_data(a0 + 4, 48, 3, "R3");
      chk(pn - p0 == 3, "R3", pn - p0, 3);
      chk(frame_id == 7, "R9", frame_id, 7);
    end

    // Zero-length descriptor at 12
    do_reset();
    head_addr = 12; a0 = an; p0 = pn;
    pulse();
    repeat (60) @(negedge clk);
    chk(an - a0 == 4, "R8", an - a0, 4);
    check_desc(a0, 12, "R8");
    chk(pn == p0, "R8", pn - p0, 0);
    chk(frame_id == 3, "R9", frame_id, 3);

    // Queue gating on the 20-word pixel descriptor at 4
    do_reset();
    head_addr = 4; pbase = pn; cap = 8; a0 = an; p0 = pn;
    pulse();
    repeat (80) @(negedge clk);
    chk(an - a0 == 4, "R7", an - a0, 4);
    chk(pn == p0, "R7", pn - p0, 0);
    cap = 16;
    repeat (120) @(negedge clk);
    chk(pn - p0 == 16, "R7", pn - p0, 16);
    check_data(a0 + 4, 40, 16, "R7");
    pbase = pn;
    repeat (80) @(negedge clk);
    chk(pn - p0 == 20, "R7", pn - p0, 20);
    for (int k = 0; k < 20; k++)
      chk(pix_log[p0+k] == dval(40 + k), "R7", pix_log[p0+k], dval(40 + k));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule